// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is a general-purpose I/O port, eight pins wide by default, that sits behind a simple single-cycle register bus inside a 4 KB address window. A per-pin direction register chooses between driving a pin and sensing it. The data register is reached through the lower 1 KB of the window. In that region, address bits [9:2] act as a bit mask for the access. Software can therefore set or clear one pin, or any group of pins, with a single write, and never needs a read-modify-write sequence.

Pins configured as outputs take their level from the data register. Pins configured as inputs leave their output line high, and their external level is sampled into the data register through a two-flop synchronizer. The window also holds a set of pad-configuration byte registers and twelve read-only identification bytes, which come from a parameter. Every other offset reads as zero, and writes to it are discarded.

Reads are registered: the byte addressed in a cycle where `bus_en` is high and `bus_we` is low appears on `bus_rdata` after the next rising clock edge, and stays there until the next read.

Top module: `gpio_mask_port`

## Requirements
- R1: A read at any offset below 0x400 returns the data register ANDed with address bits [9:2]; address bits [1:0] are ignored.
- R2: A write at an offset below 0x400 changes only the data bits that are set both in address bits [9:2] and in the direction register; all other data bits keep their value.
- R3: The direction register at offset 0x400 is read/write, holds 1 for output and 0 for input per pin, and resets to 0x00.
- R4: The pin output vector equals (data AND direction) OR NOT direction, so every input pin and every pin during reset drives high.
- R5: For an input pin, a level applied to `pin_in` and held is loaded into the data register at the third rising edge after it is applied; a read issued in the cycle of that third edge still returns the old level, and a read issued in the following cycle returns the new one.
- R6: `pin_in` has no effect on data bits whose direction bit is 1, and data writes have no effect on data bits whose direction bit is 0.
- R7: Word offsets 0xFD0 to 0xFFC return identification byte number (offset − 0xFD0) >> 2 of the `ID_BYTES` parameter, taken from bits [8n+7:8n].
- R8: Nine pad-configuration registers are read/write at word offsets 0x500, 0x504, 0x508, 0x50C, 0x510, 0x514, 0x518, 0x51C and 0x528. The register at 0x500 resets to all ones and the others reset to zero.
- R9: All other offsets read as zero, and writes to them change no register: 0x404 to 0x4FC, 0x520, 0x524, and 0x52C to 0xFCC.
- R10: Read data appears on `bus_rdata` after the rising edge that samples the read request, and it holds its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; internally released in step with the clock |
| bus_en | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the 4 KB window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | External pin levels (asynchronous) |
| pin_out | output | 8 | Pin output levels |

## Verification
The bench builds the port with its default eight pins and an identification parameter of its own choosing. At that width the direction register has only 256 values, and the address mask also has only 256 values. The bench therefore sweeps every direction value against the output vector, and every mask value for both masked writes and masked reads. With an address window of only 1024 words, the bench also visits every reserved word, reading it and then writing to it. It then confirms that no readable register has moved. Input capture is timed to the exact edge for several pin patterns, and mixed-direction cases show that pin levels and masked writes each touch only their own bits.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned WORD_W   = ADDR_W - 2;
  localparam int unsigned NUM_PAD  = 9;
  localparam int unsigned NUM_ID   = 12;
  localparam int unsigned ID_IDX_W = $clog2(NUM_ID);

  localparam logic [WORD_W-1:0] WORD_DIR     = 10'h100;
  localparam logic [WORD_W-1:0] WORD_PAD_LO  = 10'h140;
  localparam logic [WORD_W-1:0] WORD_ANALOG  = 10'h14A;
  localparam logic [WORD_W-1:0] WORD_ID_LO   = 10'h3F4;

  typedef struct packed {
    logic                sel_data;
    logic                sel_dir;
    logic [NUM_PAD-1:0]  sel_pad;
    logic                sel_id;
    logic [ID_IDX_W-1:0] id_idx;
  } dec_t;

  function automatic logic [WORD_W-1:0] pad_word(input int unsigned idx);
    if (idx < NUM_PAD - 1) return WORD_PAD_LO + WORD_W'(idx);
    return WORD_ANALOG;
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_mask_pkg::*;
(
  input  logic [WORD_W-1:0] word_addr,
  output dec_t              dec
);

  logic [WORD_W-1:0] id_off;

  assign id_off = word_addr - WORD_ID_LO;

  always_comb begin
    dec          = '0;
    dec.sel_data = (word_addr[WORD_W-1 -: 2] == 2'b00);
    dec.sel_dir  = (word_addr == WORD_DIR);
    for (int unsigned i = 0; i < NUM_PAD; i++) begin
      dec.sel_pad[i] = (word_addr == pad_word(i));
    end
    dec.sel_id   = (word_addr >= WORD_ID_LO);
    dec.id_idx   = id_off[ID_IDX_W-1:0];
  end

endmodule

// File: rtl/gpio_data_path.sv
module gpio_data_path #(
  parameter int unsigned PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_en,
  input  logic [PIN_W-1:0] wr_mask,
  input  logic [PIN_W-1:0] wr_data,
  input  logic [PIN_W-1:0] dir,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] data_q,
  output logic [PIN_W-1:0] pin_out
);

  logic [PIN_W-1:0] pin_sync;
  logic [PIN_W-1:0] data_d;

  // two-flop synchronizer, one pair per pin
  for (genvar i = 0; i < PIN_W; i++) begin : g_sync
    logic meta_q;
    logic safe_q;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        safe_q <= 1'b0;
      end else begin
        meta_q <= pin_in[i];
        safe_q <= meta_q;
      end
    end
    assign pin_sync[i] = safe_q;
  end

  always_comb begin
    for (int unsigned i = 0; i < PIN_W; i++) begin
      if (!dir[i]) begin
        data_d[i] = pin_sync[i];
      end else if (wr_en && wr_mask[i]) begin
        data_d[i] = wr_data[i];
      end else begin
        data_d[i] = data_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_d;
  end

  assign pin_out = (data_q & dir) | ~dir;

  // input pins follow the synchronized level one edge later
  p_in_capture_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (((data_q ^ $past(pin_sync)) & ~$past(dir)) == '0));

  // output pins outside the write mask hold their value
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (((data_q ^ $past(data_q)) & $past(dir) &
               ~($past(wr_mask) & {PIN_W{$past(wr_en)}})) == '0));

  // pins set as inputs never pull their output line low
  p_float_high_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    ((~dir & ~pin_out) == '0));

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_mask_pkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic                          wr_en,
  input  logic                          sel_dir,
  input  logic [NUM_PAD-1:0]            sel_pad,
  input  logic [PIN_W-1:0]              wr_data,
  output logic [PIN_W-1:0]              dir_q,
  output logic [NUM_PAD-1:0][PIN_W-1:0] pad_q
);

  logic             dir_en;
  logic [PIN_W-1:0] dir_d;

  assign dir_en = wr_en & sel_dir;
  assign dir_d  = wr_data;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  for (genvar i = 0; i < NUM_PAD; i++) begin : g_pad
    localparam logic [PIN_W-1:0] RST_VAL = (i == 0) ? '1 : '0;
    logic             pad_en;
    logic [PIN_W-1:0] pad_d;
    assign pad_en = wr_en & sel_pad[i];
    assign pad_d  = wr_data;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)     pad_q[i] <= RST_VAL;
      else if (pad_en) pad_q[i] <= pad_d;
    end
  end

  p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && sel_dir) |=> (dir_q == $past(wr_data)));

  p_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !(wr_en && sel_dir) |=> $stable(dir_q));

  p_pad_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !(wr_en && (|sel_pad)) |=> $stable(pad_q));

  p_pad_onehot_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(sel_pad));

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_mask_pkg::*;
#(
  parameter int unsigned      PIN_W    = 8,
  parameter logic [8*NUM_ID-1:0] ID_BYTES = '0
) (
  input  logic                          clk,
  input  logic                          rst_ni,
  input  logic                          rd_en,
  input  dec_t                          dec,
  input  logic [PIN_W-1:0]              rd_mask,
  input  logic [PIN_W-1:0]              data_q,
  input  logic [PIN_W-1:0]              dir_q,
  input  logic [NUM_PAD-1:0][PIN_W-1:0] pad_q,
  output logic [PIN_W-1:0]              rdata_q
);

  logic [PIN_W-1:0] rdata_d;
  logic [7:0]       id_byte;
  logic             hit_any;

  assign id_byte = ID_BYTES[{dec.id_idx, 3'b000} +: 8];
  assign hit_any = dec.sel_data | dec.sel_dir | (|dec.sel_pad) | dec.sel_id;

  always_comb begin
    rdata_d = '0;
    if (dec.sel_data) rdata_d = data_q & rd_mask;
    if (dec.sel_dir)  rdata_d = dir_q;
    for (int unsigned i = 0; i < NUM_PAD; i++) begin
      if (dec.sel_pad[i]) rdata_d = pad_q[i];
    end
    if (dec.sel_id)   rdata_d = PIN_W'(id_byte);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en && !hit_any) |=> (rdata_q == '0));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en |=> $stable(rdata_q));

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned         PIN_W    = 8,
  parameter logic [8*NUM_ID-1:0] ID_BYTES = 96'h3C_96_A5_5A_00_00_00_2E_00_00_00_00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out
);

  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  logic                          wr_en;
  logic                          rd_en;
  logic [PIN_W-1:0]              acc_mask;
  dec_t                          dec;
  logic [PIN_W-1:0]              data_q;
  logic [PIN_W-1:0]              dir_q;
  logic [NUM_PAD-1:0][PIN_W-1:0] pad_q;
  logic                          unused_byte_lane;

  assign wr_en            = bus_en & bus_we;
  assign rd_en            = bus_en & ~bus_we;
  assign acc_mask         = bus_addr[2 +: PIN_W];
  assign unused_byte_lane = ^bus_addr[1:0];

  gpio_addr_dec u_dec (
    .word_addr (bus_addr[ADDR_W-1:2]),
    .dec       (dec)
  );

  gpio_data_path #(.PIN_W(PIN_W)) u_data (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_en   (wr_en & dec.sel_data),
    .wr_mask (acc_mask),
    .wr_data (bus_wdata),
    .dir     (dir_q),
    .pin_in  (pin_in),
    .data_q  (data_q),
    .pin_out (pin_out)
  );

  gpio_cfg_regs #(.PIN_W(PIN_W)) u_cfg (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_en   (wr_en),
    .sel_dir (dec.sel_dir),
    .sel_pad (dec.sel_pad),
    .wr_data (bus_wdata),
    .dir_q   (dir_q),
    .pad_q   (pad_q)
  );

  gpio_rd_mux #(.PIN_W(PIN_W), .ID_BYTES(ID_BYTES)) u_rd (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .rd_en   (rd_en),
    .dec     (dec),
    .rd_mask (acc_mask),
    .data_q  (data_q),
    .dir_q   (dir_q),
    .pad_q   (pad_q),
    .rdata_q (bus_rdata)
  );

  p_data_read_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en && dec.sel_data) |=> (bus_rdata == ($past(data_q) & $past(acc_mask))));

  p_id_read_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en && dec.sel_id) |=> (bus_rdata == PIN_W'(ID_BYTES[{$past(dec.id_idx), 3'b000} +: 8])));

endmodule

// File: tb/sim_gpio_mask_port.sv
module sim_gpio_mask_port;

  localparam logic [95:0] IDV = 96'hD2_4B_19_E7_00_00_00_6C_00_00_00_00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, pin_in, pin_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_mask_port #(.PIN_W(8), .ID_BYTES(IDV)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [11:0] pad_addr(input int i);
    return (i < 8) ? 12'(12'h500 + 4*i) : 12'h528;
  endfunction

  function automatic bit is_reserved(input int w);
    return (w >= 12'h101 && w <= 12'h13F) || w == 12'h148 || w == 12'h149 ||
           (w >= 12'h14B && w <= 12'h3F3);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, dm, v, prev;
    logic [7:0] pads [9];
    logic [7:0] pats [5];
    pats = '{8'h96, 8'h69, 8'hFF, 8'h00, 8'h5A};
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    chk("R4 reset outputs high", pin_out, 8'hFF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(12'h400, r); chk("R3 dir reset", r, 8'h00);
    for (int i = 0; i < 9; i++) begin
      rd(pad_addr(i), r); chk("R8 pad reset", r, (i == 0) ? 8'hFF : 8'h00);
      pads[i] = (i == 0) ? 8'hFF : 8'h00;
    end
    rd(12'h3FC, r); chk("R1 data reset", r, 8'h00);

    // every direction value against the output vector
    for (int d = 0; d < 256; d++) begin
      v = 8'(d) ^ 8'h3C;
      wr(12'h400, 8'(d));
      wr(12'h3FC, v);
      chk("R4 output vector", pin_out, (v & 8'(d)) | ~8'(d));
      rd(12'h400, r); chk("R3 dir readback", r, 8'(d));
    end

    // every write mask with all pins driven
    wr(12'h400, 8'hFF);
    wr(12'h3FC, 8'h00);
    dm = 8'h00;
    for (int m = 0; m < 256; m++) begin
      v = 8'(m * 37 + 11);
      wr({2'b00, 8'(m), 2'b00}, v);
      dm = (dm & ~8'(m)) | (v & 8'(m));
      chk("R2 masked write", pin_out, dm);
    end

    // every read mask, low address bits varied
    for (int m = 0; m < 256; m++) begin
      rd({2'b00, 8'(m), 2'(m)}, r);
      chk("R1 masked read", r, dm & 8'(m));
    end

    // input capture timing
    wr(12'h400, 8'h00);
    pin_in = 8'h00;
    repeat (4) @(negedge clk);
    prev = 8'h00;
    foreach (pats[k]) begin
      pin_in = pats[k];
      for (int e = 0; e < 3; e++) begin
        rd(12'h3FC, r); chk("R5 capture not yet", r, prev);
      end
      rd(12'h3FC, r); chk("R5 capture at third edge", r, pats[k]);
      chk("R4 inputs float high", pin_out, 8'hFF);
      prev = pats[k];
    end

    // mixed directions
    wr(12'h400, 8'h0F);
    wr(12'h3FC, 8'h05);
    pin_in = 8'hAA;
    repeat (4) @(negedge clk);
    rd(12'h3FC, r); chk("R6 mixed read", r, 8'hA5);
    chk("R6 mixed outputs", pin_out, 8'hF5);
    wr(12'h3FC, 8'hFF);
    rd(12'h3FC, r); chk("R6 write skips input pins", r, 8'hAF);
    chk("R6 outputs after write", pin_out, 8'hFF);
    pin_in = 8'h55;
    repeat (4) @(negedge clk);
    rd(12'h3FC, r); chk("R6 pin_in skips output pins", r, 8'h5F);

    // identification bytes
    for (int i = 0; i < 12; i++) begin
      rd(12'(12'hFD0 + 4*i + (i % 4)), r);
      chk("R7 id byte", r, IDV[8*i +: 8]);
    end

    // pad registers
    for (int i = 0; i < 9; i++) begin
      pads[i] = 8'(8'h13 * (i + 1) + 8'h40);
      wr(pad_addr(i), pads[i]);
    end
    for (int i = 0; i < 9; i++) begin
      rd(pad_addr(i), r); chk("R8 pad readback", r, pads[i]);
    end

    // reserved sweep
    for (int w = 12'h101; w <= 12'h3F3; w++) begin
      if (is_reserved(w)) begin
        rd(12'(w * 4), r); chk("R9 reserved reads zero", r, 8'h00);
        wr(12'(w * 4), 8'hFF);
      end
    end
    rd(12'h400, r); chk("R9 dir untouched", r, 8'h0F);
    for (int i = 0; i < 9; i++) begin
      rd(pad_addr(i), r); chk("R9 pad untouched", r, pads[i]);
    end
    rd(12'h3FC, r); chk("R9 data untouched", r, 8'h5F);
    chk("R9 outputs untouched", pin_out, 8'hFF);

    // read data holds without a request
    rd(12'h400, r);
    bus_addr = 12'h500; bus_we = 1'b0; bus_en = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 rdata holds", bus_rdata, 8'h0F);
    rd(12'h500, r); chk("R10 next read", r, pads[0]);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule